// File: doc/BRIEF.md
# Master-Channel Output Compare Timer Slice

This block is a four-channel slice of a 16-bit output-compare timer. A free-running counter is compared every cycle against one 16-bit compare value per channel. Channels 4, 5 and 6 each carry their own pin action: none, toggle, clear or set. Channel 7 is the master channel. When it matches, it forces every pin whose override-mask bit is set to the value held in a matching override-data bit. The master wins over any compare of the other channels on the same pin in the same cycle.

Software sets up the slice through a byte-wide register port with a combinational read path. Through this port it loads the compare values, the output-compare select bits, the per-channel actions and the mask/data pair. It can also read back the counter. The pins are registered, and each pin has an output-enable.

Top module: `oc_override_timer`

## Requirements
- R1: The counter resets to 0, advances by one on every clock and wraps from 16'hFFFF to 0.
- R2: The counter reads as its high byte at address 0x04 and its low byte at 0x05. Writes to either address are ignored.
- R3: The override-mask register (0x00) and the override-data register (0x01) reset to zero and are writable at any time. Bit 4+k belongs to channel 4+k (k = 0..3). Bits 3:0 read as zero.
- R4: The select register (0x02) uses bits 4+k, where a 1 selects output compare on channel 4+k. The action register (0x03) holds the ch4 action in [1:0], ch5 in [3:2] and ch6 in [5:4]. The action encodings are 00 none, 01 toggle, 10 clear and 11 set. Channel 4+k compare value is at 0x08+2k (high byte) and 0x09+2k (low byte). All of these reset to zero and read back what was written.
- R5: A selected channel matches in the cycle in which the counter equals its compare value. The pin effect is visible from the following cycle.
- R6: On a channel 4–6 match that is not overridden, the pin follows that channel's action.
- R7: On a selected channel 7 match, every pin whose mask bit is set takes its data bit. This includes the channel 7 pin itself.
- R8: When channel 7 and a masked channel 4–6 match in the same cycle, the data bit wins over the channel's own action.
- R9: Pins with a clear mask bit are unaffected by a channel 7 match and still apply their own action.
- R10: For channels 4–6, pin_oe is set when the channel is selected and either its mask bit is set or its action is not none. For channel 7, pin_oe is set when it is selected and its mask bit is set.
- R11: Pins reset to 0 and hold their value in cycles with no effective match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pin_out | output | 4 | Pin values, bit k for channel 4+k |
| pin_oe | output | 4 | Pin output enables, bit k for channel 4+k |

## Verification
The hardest state to reach from the ports is a cycle in which channel 7 and a masked channel match together while unmasked channels also match. The counter cannot be loaded, so the bench reads the live count and programs all four compare values to one future count. It then polls the count to stand exactly on the match cycle. The pin state is sampled one cycle before and one cycle after the match. The chosen action and data values make each outcome differ from what the losing source would produce: a clear action against a data bit of 1, and a second round with data 0 against a set pin.

// File: rtl/oct_pkg.sv
// Package: shared constants, register addresses and the action encoding
// for the master-channel output compare slice.
package oct_pkg;
    localparam int CNT_W  = 16;
    localparam int N_CH   = 4;
    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    localparam logic [ADDR_W-1:0] A_MASK = 5'h00;
    localparam logic [ADDR_W-1:0] A_DATA = 5'h01;
    localparam logic [ADDR_W-1:0] A_SEL  = 5'h02;
    localparam logic [ADDR_W-1:0] A_ACT  = 5'h03;
    localparam logic [ADDR_W-1:0] A_CNTH = 5'h04;
    localparam logic [ADDR_W-1:0] A_CNTL = 5'h05;
    localparam logic [ADDR_W-1:0] A_CMP0 = 5'h08;
endpackage

// File: rtl/oct_counter.sv
// Module: oct_counter
// Free-running up counter with a synchronous active-low reset.
// Assumes: no load path; the counter wraps naturally at 2**W.
module oct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt
);
    // Advance the count every clock, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt == W'($past(cnt) + 1'b1));
endmodule

// File: rtl/oct_regs.sv
// Module: oct_regs
// Byte-wide register file: override mask/data, select, actions and
// compare values, plus the combinational read mux including the counter.
// Assumes: CNT_W is twice the byte width, and N_CH <= 4 so that the
// per-channel fields fit in one byte.
module oct_regs
    import oct_pkg::*;
#(
    parameter int N_CH_P = N_CH,
    parameter int CW     = CNT_W,
    parameter int AW     = ADDR_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [AW-1:0]                addr,
    input  logic [7:0]                   wdata,
    input  logic [CW-1:0]                cnt,
    output logic [7:0]                   rdata,
    output logic [N_CH_P-1:0]            mask,
    output logic [N_CH_P-1:0]            data,
    output logic [N_CH_P-1:0]            sel,
    output logic [2*(N_CH_P-1)-1:0]      act_bits,
    output logic [N_CH_P-1:0][CW-1:0]    cmp
);
    localparam int HALF = CW / 2;
    localparam int FLD  = 8 - N_CH_P;
    localparam int ACTW = 2 * (N_CH_P - 1);

    // Update the control registers on a write to their address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask     <= '0;
            data     <= '0;
            sel      <= '0;
            act_bits <= '0;
        end else if (we) begin
            if (addr == A_MASK) mask     <= wdata[FLD +: N_CH_P];
            if (addr == A_DATA) data     <= wdata[FLD +: N_CH_P];
            if (addr == A_SEL)  sel      <= wdata[FLD +: N_CH_P];
            if (addr == A_ACT)  act_bits <= wdata[ACTW-1:0];
        end
    end

    // One high/low byte pair per channel compare value.
    for (genvar k = 0; k < N_CH_P; k++) begin : g_cmp
        // Load the addressed byte of this channel's compare value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp[k] <= '0;
            end else if (we) begin
                if (int'(addr) == int'(A_CMP0) + 2*k)     cmp[k][CW-1:HALF] <= wdata;
                if (int'(addr) == int'(A_CMP0) + 2*k + 1) cmp[k][HALF-1:0]  <= wdata;
            end
        end
    end

    // Select the addressed register onto the read bus; unmapped reads zero.
    always_comb begin
        rdata = '0;
        if (addr == A_MASK) rdata[FLD +: N_CH_P] = mask;
        if (addr == A_DATA) rdata[FLD +: N_CH_P] = data;
        if (addr == A_SEL)  rdata[FLD +: N_CH_P] = sel;
        if (addr == A_ACT)  rdata[ACTW-1:0]      = act_bits;
        if (addr == A_CNTH) rdata = cnt[CW-1:HALF];
        if (addr == A_CNTL) rdata = cnt[HALF-1:0];
        for (int k = 0; k < N_CH_P; k++) begin
            if (int'(addr) == int'(A_CMP0) + 2*k)     rdata = cmp[k][CW-1:HALF];
            if (int'(addr) == int'(A_CMP0) + 2*k + 1) rdata = cmp[k][HALF-1:0];
        end
    end

    // R3
    mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_MASK) |=> mask == $past(wdata[FLD +: N_CH_P]));

    // R3
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_MASK || addr == A_DATA) |-> rdata[FLD-1:0] == '0);
endmodule

// File: rtl/oct_pin_logic.sv
// Module: oct_pin_logic
// Compare matching, per-pin next-value selection with master override,
// pin registers and output enables.
// Assumes: the top channel (index N_CH_P-1) is the master; the others
// each own a 2-bit action field in act_bits.
module oct_pin_logic
    import oct_pkg::*;
#(
    parameter int N_CH_P = N_CH,
    parameter int CW     = CNT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CW-1:0]              cnt,
    input  logic [N_CH_P-1:0][CW-1:0]  cmp,
    input  logic [N_CH_P-1:0]          sel,
    input  logic [N_CH_P-1:0]          mask,
    input  logic [N_CH_P-1:0]          data,
    input  logic [2*(N_CH_P-1)-1:0]    act_bits,
    output logic [N_CH_P-1:0]          pin_out,
    output logic [N_CH_P-1:0]          pin_oe
);
    localparam int MST = N_CH_P - 1;

    logic [N_CH_P-1:0] hit;
    logic [N_CH_P-1:0] nxt;
    logic              m_fire;

    assign m_fire = hit[MST];

    for (genvar k = 0; k < N_CH_P; k++) begin : g_ch
        // Channel match: selected and the count equals the compare value.
        assign hit[k] = sel[k] && (cnt == cmp[k]);

        if (k == MST) begin : g_master
            // Master pin changes only through its own mask/data pair.
            always_comb begin
                nxt[k] = pin_out[k];
                if (m_fire && mask[k]) nxt[k] = data[k];
            end
            assign pin_oe[k] = sel[k] && mask[k];
        end else begin : g_slave
            act_e act;
            assign act = act_e'(act_bits[2*k +: 2]);

            // Override first, then this channel's own action, else hold.
            always_comb begin
                nxt[k] = pin_out[k];
                if (m_fire && mask[k]) begin
                    nxt[k] = data[k];
                end else if (hit[k]) begin
                    case (act)
                        ACT_TOGGLE: nxt[k] = ~pin_out[k];
                        ACT_CLEAR:  nxt[k] = 1'b0;
                        ACT_SET:    nxt[k] = 1'b1;
                        default:    nxt[k] = pin_out[k];
                    endcase
                end
            end
            assign pin_oe[k] = sel[k] && (mask[k] || act != ACT_NONE);

            // R6
            own_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hit[k] && !(m_fire && mask[k]) && act == ACT_SET) |=> pin_out[k]);
        end

        // R7 R8
        override_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m_fire && mask[k]) |=> pin_out[k] == $past(data[k]));

        // R11
        pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!(m_fire && mask[k]) && !hit[k]) |=> pin_out[k] == $past(pin_out[k]));
    end

    // Register the pin values.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_out <= '0;
        else        pin_out <= nxt;
    end
endmodule

// File: rtl/oc_override_timer.sv
// Module: oc_override_timer (top)
// Four-channel output compare slice in which the master channel's match
// forces masked pins to preset data values.
// Assumes: a single clock domain; register reads are combinational.
module oc_override_timer
    import oct_pkg::*;
#(
    parameter int N_CH_P = N_CH,
    parameter int CW     = CNT_W,
    parameter int AW     = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [N_CH_P-1:0] pin_out,
    output logic [N_CH_P-1:0] pin_oe
);
    logic [CW-1:0]             cnt;
    logic [N_CH_P-1:0]         mask;
    logic [N_CH_P-1:0]         data;
    logic [N_CH_P-1:0]         sel;
    logic [2*(N_CH_P-1)-1:0]   act_bits;
    logic [N_CH_P-1:0][CW-1:0] cmp;

    oct_counter #(.W(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt)
    );

    oct_regs #(.N_CH_P(N_CH_P), .CW(CW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .cnt      (cnt),
        .rdata    (reg_rdata),
        .mask     (mask),
        .data     (data),
        .sel      (sel),
        .act_bits (act_bits),
        .cmp      (cmp)
    );

    oct_pin_logic #(.N_CH_P(N_CH_P), .CW(CW)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .cmp      (cmp),
        .sel      (sel),
        .mask     (mask),
        .data     (data),
        .act_bits (act_bits),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    // R2
    cnt_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && reg_we && (reg_addr == A_CNTH || reg_addr == A_CNTL))
        |=> cnt == CW'($past(cnt) + 1'b1));
endmodule

// File: tb/oc_override_timer_tb.sv
module oc_override_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_we;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    oc_override_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_cnt(output logic [15:0] c);
        logic [7:0] h, l;
        rd(5'h04, h);
        rd(5'h05, l);
        c = {h, l};
    endtask

    task automatic wait_cnt(input logic [15:0] t);
        logic [15:0] c;
        rd_cnt(c);
        while (c != t) begin
            @(negedge clk);
            rd_cnt(c);
        end
    endtask

    task automatic set_cmp(input int k, input logic [15:0] v);
        wr(5'(8 + 2*k), v[15:8]);
        wr(5'(9 + 2*k), v[7:0]);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        logic [15:0] c;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rd_cnt(c);     check("R1 counter in reset", c, 16'h0000);
        rd(5'h00, d);  check("R3 mask reset", d, 8'h00);
        rd(5'h0B, d);  check("R4 cmp5 lo reset", d, 8'h00);
        check("R11 pins reset", pin_out, 4'h0);
        check("R10 oe reset", pin_oe, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_cnt(c);     check("R1 first count after reset", c, 16'h0001);
    endtask

    task automatic t_regs;
        logic [7:0] d;
        wr(5'h00, 8'hFF); rd(5'h00, d); check("R3 mask readback low zero", d, 8'hF0);
        wr(5'h01, 8'h5A); rd(5'h01, d); check("R3 data readback", d, 8'h50);
        wr(5'h03, 8'hFF); rd(5'h03, d); check("R4 action readback", d, 8'h3F);
        wr(5'h0E, 8'hC3); rd(5'h0E, d); check("R4 cmp7 hi readback", d, 8'hC3);
        wr(5'h00, 8'h00); wr(5'h01, 8'h00); wr(5'h03, 8'h00);
    endtask

    task automatic t_counter;
        logic [15:0] c0, c1;
        rd_cnt(c0);
        @(negedge clk);
        rd_cnt(c1); check("R1 increment", c1, 16'(c0 + 1));
        rd_cnt(c0);
        wr(5'h04, 8'h00);
        wr(5'h05, 8'h00);
        rd_cnt(c1); check("R2 counter writes ignored", c1, 16'(c0 + 4));
        wait_cnt(16'hFFFF);
        @(negedge clk);
        rd_cnt(c1); check("R1 wrap to zero", c1, 16'h0000);
    endtask

    task automatic t_own_actions;
        logic [15:0] c, t;
        wr(5'h02, 8'h10);
        wr(5'h03, 8'h03);
        rd_cnt(c); t = c + 16'd20;
        set_cmp(0, t);
        wait_cnt(t);
        check("R5 no effect in match cycle", pin_out[0], 1'b0);
        @(negedge clk);
        check("R6 set action", pin_out[0], 1'b1);
        repeat (5) @(negedge clk);
        check("R11 pin holds", pin_out[0], 1'b1);
        wr(5'h03, 8'h01);
        rd_cnt(c); t = c + 16'd20;
        set_cmp(0, t);
        wait_cnt(t);
        @(negedge clk);
        check("R6 toggle action", pin_out[0], 1'b0);
    endtask

    task automatic t_override;
        logic [15:0] c, t;
        wr(5'h02, 8'hF0);
        wr(5'h03, 8'h39);
        wr(5'h00, 8'hA0);
        wr(5'h01, 8'hA0);
        rd_cnt(c); t = c + 16'd40;
        for (int k = 0; k < 4; k++) set_cmp(k, t);
        check("R10 oe all enabled", pin_oe, 4'hF);
        wait_cnt(t);
        check("R5 pins before match", pin_out, 4'h0);
        @(negedge clk);
        check("R8 data beats clear on ch5", pin_out[1], 1'b1);
        check("R7 master pin takes data", pin_out[3], 1'b1);
        check("R9 unmasked ch4 toggles", pin_out[0], 1'b1);
        check("R9 unmasked ch6 sets", pin_out[2], 1'b1);
        wr(5'h01, 8'h00);
        rd_cnt(c); t = c + 16'd40;
        for (int k = 0; k < 4; k++) set_cmp(k, t);
        wait_cnt(t);
        @(negedge clk);
        check("R8 data zero wins on ch5", pin_out[1], 1'b0);
        check("R7 master pin data zero", pin_out[3], 1'b0);
        check("R9 ch4 toggles back", pin_out[0], 1'b0);
        check("R9 ch6 stays set", pin_out[2], 1'b1);
    endtask

    task automatic t_oe;
        wr(5'h03, 8'h00);
        wr(5'h00, 8'h20);
        check("R10 oe mask only ch5", pin_oe, 4'b0010);
        wr(5'h03, 8'h02);
        check("R10 oe action ch4", pin_oe, 4'b0011);
        wr(5'h02, 8'h00);
        check("R10 oe unselected", pin_oe, 4'b0000);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset;
        t_regs;
        t_counter;
        t_own_actions;
        t_override;
        t_oe;
        report;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        report;
    end
endmodule